// File: doc/BRIEF.md
# Parameterized Set-Associative Write-Back Cache

This block is a small write-back cache placed between one requester and a slower next-level memory. The requester issues single-byte reads and writes. Each access gets back a hit flag, a miss class and a data byte. The geometry is set by parameters: address width, block size (as a power of two), set count (as a power of two) and number of ways. Setting the way count to one gives a direct-mapped cache built from the same source.

A byte address is split into three fields. The low bits select the byte within a block. The next bits pick the set. All remaining upper bits form the tag that is stored and compared. When a miss has to displace a modified line, that line is first written to the next level as one whole-block write. The missing block is then read as one whole-block transfer. Each transfer uses a level request held until a one-cycle acknowledge. When the fill ends, the access that missed completes and gets its response.

Top module: `sa_cache`

## Requirements
- R1: Address bits [OFF_W-1:0] are the byte offset, bits [OFF_W+SET_W-1:OFF_W] are the set index, and the remaining upper bits are the tag. Two addresses map to the same set exactly when their index bits are equal.
- R2: An access hits when any way of its set is valid and holds the address tag. A hit gives resp_valid=1 and resp_hit=1 in the first cycle after acceptance, and busy stays low.
- R3: The returned byte is the byte at the block offset of the addressed block. For a read, this is the value most recently written to that address, or the initial memory content if it was never written. For a write, resp_rdata returns the written byte.
- R4: A request is accepted only while busy is low. After a miss is accepted, busy is high from the next cycle until the cycle in which the miss response appears. mem_req is high only while busy is high.
- R5: A miss fills the lowest-numbered invalid way of its set. If the set is full, it replaces the way whose last use is oldest.
- R6: If the replaced line is valid and dirty, it is written to the next level (mem_we=1, mem_addr = stored tag concatenated with set index) before the missing block is read (mem_we=0). A clean or invalid victim causes no next-level write.
- R7: A write miss fetches the block, merges the byte into it and marks the line dirty. A write hit updates the byte and marks the line dirty without any next-level transfer.
- R8: resp_cold is 1 exactly for misses that fill a way which was invalid. It is 0 for hits and for misses that replace a valid line.
- R9: After reset, busy, resp_valid and mem_req are low, and every way is invalid and clean.
- R10: With 4-bit addresses, 2-byte blocks, 4 sets and 1 way, reads of 0,1,7,8,0 give miss, hit, miss, miss, miss, and alternating reads of 0 and 8 miss every time.
- R11: With 4-bit addresses, 2-byte blocks, 2 sets and 2 ways, reads of 0,1,7,8,0 give miss, hit, miss, miss, hit.
- R12: A miss completes with a response in the cycle after the fill acknowledge. The filled line then counts as most recently used, so an immediate repeat access to the same block hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, taken when busy is low |
| req_write | input | 1 | 1 = write byte, 0 = read byte |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Miss handling in progress; requests not accepted |
| resp_valid | output | 1 | One-cycle pulse completing an access |
| resp_hit | output | 1 | Access found its block in the cache |
| resp_cold | output | 1 | Miss filled a previously invalid way |
| resp_rdata | output | 8 | Byte read, or the byte written |
| mem_req | output | 1 | Next-level transfer request, held until acknowledged |
| mem_we | output | 1 | 1 = write back a victim block, 0 = fetch a block |
| mem_addr | output | ADDR_W-OFF_W | Block address of the transfer |
| mem_wdata | output | 8<<OFF_W | Victim block contents |
| mem_ack | input | 1 | One-cycle completion of the transfer |
| mem_rdata | input | 8<<OFF_W | Fetched block contents, valid with mem_ack |

## Verification
A hit response is due in the first cycle after the accepting edge. The bench therefore samples at the falling edge that follows acceptance and expects resp_valid with busy low. A miss must instead show busy high at that same falling edge. Its response arrives one cycle after the last next-level acknowledge, so the bench polls at falling edges and then checks hit, miss class, data and the number of next-level writes against a timestamp-LRU model kept in the bench. Outputs are never sampled at the rising edge, which keeps each check on the cycle in which the registered result is due.

// File: rtl/sac_pkg.sv
package sac_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WBACK = 2'd1,
      ST_FILL  = 2'd2
   } sac_state_e;

   function automatic int unsigned sac_way_w(input int unsigned ways);
      return (ways > 1) ? $clog2(ways) : 1;
   endfunction

endpackage

// File: rtl/sac_tag_match.sv
module sac_tag_match #(
   parameter int unsigned WAYS  = 2,
   parameter int unsigned TAG_W = 4,
   parameter int unsigned WAY_W = 1
) (
   input  logic [WAYS-1:0]       valid_i,
   input  logic [WAYS*TAG_W-1:0] tags_i,
   input  logic [TAG_W-1:0]      tag_i,
   output logic                  hit_o,
   output logic [WAY_W-1:0]      hit_way_o,
   output logic                  any_free_o,
   output logic [WAY_W-1:0]      free_way_o
);

   if (WAYS == 1) begin : g_direct
      assign hit_o      = valid_i[0] && (tags_i == tag_i);
      assign hit_way_o  = '0;
      assign any_free_o = !valid_i[0];
      assign free_way_o = '0;
   end else begin : g_assoc
      logic [WAYS-1:0] match;
      for (genvar w = 0; w < WAYS; w++) begin : g_cmp
         assign match[w] = valid_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
      end
      assign hit_o      = |match;
      assign any_free_o = !(&valid_i);
      always_comb begin
         hit_way_o  = '0;
         free_way_o = '0;
         for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w])    hit_way_o  = WAY_W'(w);
            if (!valid_i[w]) free_way_o = WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/sac_lru.sv
module sac_lru #(
   parameter int unsigned SETS  = 8,
   parameter int unsigned WAYS  = 2,
   parameter int unsigned SET_W = 3,
   parameter int unsigned WAY_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_i,
   input  logic [SET_W-1:0] touch_set_i,
   input  logic [WAY_W-1:0] touch_way_i,
   input  logic [SET_W-1:0] rd_set_i,
   output logic [WAY_W-1:0] lru_way_o
);

   localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

   // per-line age rank: 0 = most recent, WAYS-1 = oldest; ranks in a set stay distinct
   logic [WAY_W-1:0] age_q [SETS][WAYS];
   logic [WAY_W-1:0] ref_age;

   assign ref_age = age_q[touch_set_i][touch_way_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= WAY_W'(w);
      end else if (touch_i) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way_i)
               age_q[touch_set_i][w] <= '0;
            else if (age_q[touch_set_i][w] < ref_age)
               age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
         end
      end
   end

   always_comb begin
      lru_way_o = '0;
      for (int w = 0; w < WAYS; w++)
         if (age_q[rd_set_i][w] == OLDEST) lru_way_o = WAY_W'(w);
   end

endmodule

// File: rtl/sa_cache.sv
module sa_cache
   import sac_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned OFF_W  = 2,
   parameter int unsigned SET_W  = 3,
   parameter int unsigned WAYS   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic                      req_write,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [7:0]                req_wdata,
   output logic                      busy,
   output logic                      resp_valid,
   output logic                      resp_hit,
   output logic                      resp_cold,
   output logic [7:0]                resp_rdata,
   output logic                      mem_req,
   output logic                      mem_we,
   output logic [ADDR_W-OFF_W-1:0]   mem_addr,
   output logic [(8<<OFF_W)-1:0]     mem_wdata,
   input  logic                      mem_ack,
   input  logic [(8<<OFF_W)-1:0]     mem_rdata
);

   localparam int unsigned TAG_W   = ADDR_W - SET_W - OFF_W;
   localparam int unsigned SETS    = 1 << SET_W;
   localparam int unsigned BLK_W   = 8 << OFF_W;
   localparam int unsigned WAY_W   = sac_way_w(WAYS);

   if (OFF_W < 1)                    begin : g_bad_off  $error("OFF_W must be at least 1");        end
   if (SET_W < 1)                    begin : g_bad_set  $error("SET_W must be at least 1");        end
   if (WAYS < 1)                     begin : g_bad_ways $error("WAYS must be at least 1");         end
   if (ADDR_W < OFF_W + SET_W + 1)   begin : g_bad_addr $error("ADDR_W leaves no tag bits");      end

   typedef logic [BLK_W-1:0] blk_t;

   function automatic logic [7:0] pick_byte(input blk_t blk, input logic [OFF_W-1:0] off);
      return blk[int'(off)*8 +: 8];
   endfunction

   function automatic blk_t merge_byte(input blk_t blk, input logic [OFF_W-1:0] off,
                                       input logic [7:0] b);
      blk_t r;
      r = blk;
      r[int'(off)*8 +: 8] = b;
      return r;
   endfunction

   // storage
   logic [WAYS-1:0]  valid_q [SETS];
   logic [WAYS-1:0]  dirty_q [SETS];
   logic [TAG_W-1:0] tag_q   [SETS][WAYS];
   blk_t             data_q  [SETS][WAYS];

   sac_state_e          state_q;
   logic                lat_write, lat_cold;
   logic [ADDR_W-1:0]   lat_addr;
   logic [7:0]          lat_wdata;
   logic [WAY_W-1:0]    lat_way;

   // address fields
   logic [TAG_W-1:0] req_tag, lat_tag;
   logic [SET_W-1:0] req_set, lat_set;
   logic [OFF_W-1:0] req_off, lat_off;
   assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
   assign req_set = req_addr[OFF_W +: SET_W];
   assign req_off = req_addr[OFF_W-1:0];
   assign lat_tag = lat_addr[ADDR_W-1 -: TAG_W];
   assign lat_set = lat_addr[OFF_W +: SET_W];
   assign lat_off = lat_addr[OFF_W-1:0];

   // lookup
   logic [WAYS*TAG_W-1:0] set_tags;
   logic                  hit, any_free;
   logic [WAY_W-1:0]      hit_way, free_way, lru_way, victim;
   blk_t                  hit_blk;

   always_comb begin
      for (int w = 0; w < WAYS; w++) set_tags[w*TAG_W +: TAG_W] = tag_q[req_set][w];
   end

   sac_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) i_match (
      .valid_i    (valid_q[req_set]),
      .tags_i     (set_tags),
      .tag_i      (req_tag),
      .hit_o      (hit),
      .hit_way_o  (hit_way),
      .any_free_o (any_free),
      .free_way_o (free_way)
   );

   logic             accept, fill_done, touch;
   logic [SET_W-1:0] touch_set;
   logic [WAY_W-1:0] touch_way;

   assign accept    = req_valid && (state_q == ST_IDLE);
   assign fill_done = (state_q == ST_FILL) && mem_ack;
   assign touch     = (accept && hit) || fill_done;
   assign touch_set = (state_q == ST_IDLE) ? req_set : lat_set;
   assign touch_way = (state_q == ST_IDLE) ? hit_way : lat_way;
   assign victim    = any_free ? free_way : lru_way;
   assign hit_blk   = data_q[req_set][hit_way];

   sac_lru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) i_lru (
      .clk         (clk),
      .rst_n       (rst_n),
      .touch_i     (touch),
      .touch_set_i (touch_set),
      .touch_way_i (touch_way),
      .rd_set_i    (req_set),
      .lru_way_o   (lru_way)
   );

   // control, flags and response
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
         resp_cold  <= 1'b0;
         resp_rdata <= '0;
         lat_write  <= 1'b0;
         lat_cold   <= 1'b0;
         lat_addr   <= '0;
         lat_wdata  <= '0;
         lat_way    <= '0;
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            dirty_q[s] <= '0;
         end
      end else begin
         resp_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               if (hit) begin
                  resp_valid <= 1'b1;
                  resp_hit   <= 1'b1;
                  resp_cold  <= 1'b0;
                  resp_rdata <= req_write ? req_wdata : pick_byte(hit_blk, req_off);
                  if (req_write) dirty_q[req_set][hit_way] <= 1'b1;
               end else begin
                  lat_write <= req_write;
                  lat_addr  <= req_addr;
                  lat_wdata <= req_wdata;
                  lat_way   <= victim;
                  lat_cold  <= any_free;
                  state_q   <= (valid_q[req_set][victim] && dirty_q[req_set][victim])
                               ? ST_WBACK : ST_FILL;
               end
            end
            ST_WBACK: if (mem_ack) state_q <= ST_FILL;
            ST_FILL: if (mem_ack) begin
               valid_q[lat_set][lat_way] <= 1'b1;
               dirty_q[lat_set][lat_way] <= lat_write;
               resp_valid <= 1'b1;
               resp_hit   <= 1'b0;
               resp_cold  <= lat_cold;
               resp_rdata <= lat_write ? lat_wdata : pick_byte(mem_rdata, lat_off);
               state_q    <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // tag and data arrays need no reset: valid bits qualify them
   always_ff @(posedge clk) begin
      if (accept && hit && req_write)
         data_q[req_set][hit_way] <= merge_byte(hit_blk, req_off, req_wdata);
      if (fill_done) begin
         tag_q[lat_set][lat_way]  <= lat_tag;
         data_q[lat_set][lat_way] <= lat_write ? merge_byte(mem_rdata, lat_off, lat_wdata)
                                               : mem_rdata;
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign mem_req   = (state_q != ST_IDLE);
   assign mem_we    = (state_q == ST_WBACK);
   assign mem_addr  = (state_q == ST_WBACK) ? {tag_q[lat_set][lat_way], lat_set}
                                            : lat_addr[ADDR_W-1:OFF_W];
   assign mem_wdata = data_q[lat_set][lat_way];

endmodule

// File: rtl/sac_checker.sv
module sac_checker (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic resp_valid,
   input logic resp_hit,
   input logic resp_cold,
   input logic mem_req,
   input logic mem_we,
   input logic mem_ack
);

   AST_HIT_WITHOUT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && resp_hit |-> !busy && !mem_req); // R2

   AST_COLD_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && resp_cold |-> !resp_hit); // R8

   AST_MISS_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !resp_hit |-> $past(mem_ack) && !$past(mem_we)); // R12

   AST_BUSY_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !mem_ack |=> busy); // R4

   AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy); // R4

   AST_WBACK_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ack && mem_we |=> mem_req && !mem_we); // R6

endmodule

bind sa_cache sac_checker i_sac_checker (.*);

// File: tb/test_sa_cache.sv
module test_mem #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned OFF_W  = 1
) (
   input  logic                    clk,
   input  logic                    req,
   input  logic                    we,
   input  logic [ADDR_W-OFF_W-1:0] addr,
   input  logic [(8<<OFF_W)-1:0]   wdata,
   output logic                    ack,
   output logic [(8<<OFF_W)-1:0]   rdata,
   output int                      wr_count
);
   localparam int unsigned NB = 1 << OFF_W;
   logic [7:0] mem [1<<ADDR_W];

   initial begin
      int cnt;
      cnt = 0; ack = 1'b0; rdata = '0; wr_count = 0;
      for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 8'((i * 37 + 5) & 255);
      forever begin
         @(negedge clk);
         if (ack) begin
            ack = 1'b0; cnt = 0;
         end else if (req) begin
            cnt++;
            if (cnt == 2) begin
               for (int b = 0; b < NB; b++) begin
                  if (we) mem[int'(addr) * NB + b] = wdata[b*8 +: 8];
                  else    rdata[b*8 +: 8] = mem[int'(addr) * NB + b];
               end
               if (we) wr_count++;
               ack = 1'b1;
            end
         end else cnt = 0;
      end
   end
endmodule

module test_sa_cache;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   // index 0: 2 sets x 2 ways, index 1: 4 sets x 1 way; both 4-bit addresses, 2-byte blocks
   logic       rq_v [2];
   logic       rq_w [2];
   logic [3:0] rq_a [2];
   logic [7:0] rq_d [2];
   logic       bz [2], rv [2], rh [2], rc [2];
   logic [7:0] rd [2];
   logic       mreq [2], mwe [2], mack [2];
   logic [2:0] maddr [2];
   logic [15:0] mwd [2], mrd [2];
   int         wrcnt [2];

   sa_cache #(.ADDR_W(4), .OFF_W(1), .SET_W(1), .WAYS(2)) i_sa_cache (
      .clk(clk), .rst_n(rst_n), .req_valid(rq_v[0]), .req_write(rq_w[0]),
      .req_addr(rq_a[0]), .req_wdata(rq_d[0]), .busy(bz[0]), .resp_valid(rv[0]),
      .resp_hit(rh[0]), .resp_cold(rc[0]), .resp_rdata(rd[0]), .mem_req(mreq[0]),
      .mem_we(mwe[0]), .mem_addr(maddr[0]), .mem_wdata(mwd[0]), .mem_ack(mack[0]),
      .mem_rdata(mrd[0]));
   test_mem #(.ADDR_W(4), .OFF_W(1)) i_mem0 (
      .clk(clk), .req(mreq[0]), .we(mwe[0]), .addr(maddr[0]), .wdata(mwd[0]),
      .ack(mack[0]), .rdata(mrd[0]), .wr_count(wrcnt[0]));

   sa_cache #(.ADDR_W(4), .OFF_W(1), .SET_W(2), .WAYS(1)) i_sa_cache_dm (
      .clk(clk), .rst_n(rst_n), .req_valid(rq_v[1]), .req_write(rq_w[1]),
      .req_addr(rq_a[1]), .req_wdata(rq_d[1]), .busy(bz[1]), .resp_valid(rv[1]),
      .resp_hit(rh[1]), .resp_cold(rc[1]), .resp_rdata(rd[1]), .mem_req(mreq[1]),
      .mem_we(mwe[1]), .mem_addr(maddr[1]), .mem_wdata(mwd[1]), .mem_ack(mack[1]),
      .mem_rdata(mrd[1]));
   test_mem #(.ADDR_W(4), .OFF_W(1)) i_mem1 (
      .clk(clk), .req(mreq[1]), .we(mwe[1]), .addr(maddr[1]), .wdata(mwd[1]),
      .ack(mack[1]), .rdata(mrd[1]), .wr_count(wrcnt[1]));

   int nchk = 0;
   int nfail = 0;

   // bench model: byte image and timestamp LRU per configuration
   logic [7:0] shadow [2][16];
   int  m_tag [2][4][2];
   bit  m_v   [2][4][2];
   bit  m_d   [2][4][2];
   int  m_t   [2][4][2];
   int  stamp = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int c = 0; c < 2; c++)
         for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++) begin
               m_v[c][s][w] = 0; m_d[c][s][w] = 0; m_t[c][s][w] = 0; m_tag[c][s][w] = 0;
            end
   endtask

   task automatic ref_access(input int c, input int a, input bit wr,
                             output bit h, output bit cold, output bit wb);
      int ns, nw, s, t, v;
      ns = (c == 0) ? 2 : 4;
      nw = (c == 0) ? 2 : 1;
      s  = (a >> 1) % ns;
      t  = (c == 0) ? (a >> 2) : (a >> 3);
      v  = -1; h = 0; cold = 0; wb = 0;
      stamp++;
      for (int w = 0; w < nw; w++)
         if (m_v[c][s][w] && m_tag[c][s][w] == t) begin v = w; h = 1; end
      if (!h) begin
         for (int w = nw - 1; w >= 0; w--) if (!m_v[c][s][w]) v = w;
         if (v < 0) begin
            v = 0;
            for (int w = 1; w < nw; w++) if (m_t[c][s][w] < m_t[c][s][v]) v = w;
         end
         cold = !m_v[c][s][v];
         wb   = m_v[c][s][v] && m_d[c][s][v];
         m_v[c][s][v] = 1; m_tag[c][s][v] = t; m_d[c][s][v] = 0;
      end
      if (wr) m_d[c][s][v] = 1;
      m_t[c][s][v] = stamp;
   endtask

   // call at a falling edge with busy low; returns at a falling edge after the response
   task automatic do_access(input int c, input bit wr, input int a, input logic [7:0] d,
                            input string lab, output bit got_hit, output bit got_cold);
      bit eh, ec, ewb;
      int wc0, n;
      logic [7:0] exp_rd;
      ref_access(c, a, wr, eh, ec, ewb);
      exp_rd = wr ? d : shadow[c][a];
      wc0 = wrcnt[c];
      rq_v[c] = 1'b1; rq_w[c] = wr; rq_a[c] = 4'(a); rq_d[c] = d;
      @(negedge clk);
      rq_v[c] = 1'b0;
      if (eh) chk(rv[c] === 1'b1 && bz[c] === 1'b0, "R2", "hit response after one cycle",
                  int'(rv[c]), 1);
      else    chk(bz[c] === 1'b1 && rv[c] === 1'b0, "R4", "busy after miss accept",
                  int'(bz[c]), 1);
      n = 0;
      while (rv[c] !== 1'b1 && n < 40) begin @(negedge clk); n++; end
      got_hit = rh[c]; got_cold = rc[c];
      chk(rv[c] === 1'b1 && bz[c] === 1'b0, "R4", "response with busy released",
          int'(bz[c]), 0);
      chk(rh[c] === eh, lab, $sformatf("hit flag addr %0d cfg %0d", a, c), int'(rh[c]), int'(eh));
      chk(rc[c] === ec, "R8", $sformatf("cold flag addr %0d cfg %0d", a, c), int'(rc[c]), int'(ec));
      chk(rd[c] === exp_rd, "R3", $sformatf("data addr %0d cfg %0d", a, c), int'(rd[c]), int'(exp_rd));
      chk(wrcnt[c] - wc0 == int'(ewb), "R6", $sformatf("write-backs addr %0d cfg %0d", a, c),
          wrcnt[c] - wc0, int'(ewb));
      if (wr) shadow[c][a] = d;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      for (int c = 0; c < 2; c++) rq_v[c] = 1'b0;
      repeat (3) @(negedge clk);
      for (int c = 0; c < 2; c++) begin
         chk(bz[c] === 1'b0 && rv[c] === 1'b0 && mreq[c] === 1'b0, "R9", "outputs in reset",
             int'(bz[c]) + int'(rv[c]) + int'(mreq[c]), 0);
      end
      rst_n = 1'b1;
      model_clear();
      @(negedge clk);
      for (int c = 0; c < 2; c++)
         chk(bz[c] === 1'b0 && mreq[c] === 1'b0, "R9", "idle after reset", int'(bz[c]), 0);
   endtask

   task automatic run_trace(input int c, input string lab, input int exp_hit [5],
                            input int exp_cold [5]);
      int tr [5] = '{0, 1, 7, 8, 0};
      bit h, cl;
      for (int i = 0; i < 5; i++) begin
         do_access(c, 1'b0, tr[i], 8'h00, lab, h, cl);
         chk(int'(h) == exp_hit[i], lab, $sformatf("trace step %0d hit", i), int'(h), exp_hit[i]);
         chk(int'(cl) == exp_cold[i], "R8", $sformatf("trace step %0d cold", i), int'(cl), exp_cold[i]);
      end
   endtask

   initial begin
      bit h, cl;
      logic [15:0] lf;
      for (int c = 0; c < 2; c++) begin
         rq_v[c] = 1'b0; rq_w[c] = 1'b0; rq_a[c] = '0; rq_d[c] = '0;
         for (int i = 0; i < 16; i++) shadow[c][i] = 8'((i * 37 + 5) & 255);
      end

      // direct-mapped trace
      do_reset();
      run_trace(1, "R10", '{0, 1, 0, 0, 0}, '{1, 0, 1, 0, 0});
      // two-way trace
      do_reset();
      run_trace(0, "R11", '{0, 1, 0, 0, 1}, '{1, 0, 1, 1, 0});

      // R10: blocks 0 and 8 share a direct-mapped set
      do_reset();
      for (int i = 0; i < 6; i++) begin
         do_access(1, 1'b0, (i % 2) * 8, 8'h00, "R10", h, cl);
         chk(h == 1'b0, "R10", "alternating 0/8 must miss", int'(h), 0);
      end

      // R5 and R12: LRU order in set 0 of the two-way cache (blocks 0,4,8,12)
      do_reset();
      do_access(0, 1'b0, 0, 8'h00, "R5", h, cl);
      do_access(0, 1'b0, 4, 8'h00, "R5", h, cl);
      chk(cl == 1'b1, "R5", "second way filled while invalid", int'(cl), 1);
      do_access(0, 1'b0, 0, 8'h00, "R2", h, cl);
      do_access(0, 1'b0, 8, 8'h00, "R5", h, cl);
      do_access(0, 1'b0, 0, 8'h00, "R5", h, cl);
      chk(h == 1'b1, "R5", "recently used block kept", int'(h), 1);
      do_access(0, 1'b0, 4, 8'h00, "R5", h, cl);
      chk(h == 1'b0, "R5", "oldest block was replaced", int'(h), 0);
      do_access(0, 1'b0, 4, 8'h00, "R12", h, cl);
      chk(h == 1'b1, "R12", "refilled block hits at once", int'(h), 1);
      do_access(0, 1'b0, 12, 8'h00, "R12", h, cl);
      do_access(0, 1'b0, 4, 8'h00, "R12", h, cl);
      chk(h == 1'b1, "R12", "filled line made most recent", int'(h), 1);

      // R7 and R6 on the direct-mapped cache; no reset follows, so memory stays consistent
      do_reset();
      do_access(1, 1'b1, 2, 8'hA5, "R7", h, cl);
      chk(h == 1'b0, "R7", "write miss allocates", int'(h), 0);
      do_access(1, 1'b0, 3, 8'h00, "R7", h, cl);
      chk(h == 1'b1, "R7", "rest of allocated block present", int'(h), 1);
      do_access(1, 1'b1, 3, 8'h3C, "R7", h, cl);
      chk(h == 1'b1, "R7", "write hit", int'(h), 1);
      do_access(1, 1'b0, 10, 8'h00, "R6", h, cl);
      do_access(1, 1'b0, 3, 8'h00, "R6", h, cl);
      chk(rd[1] == 8'h3C, "R6", "written-back byte refetched", int'(rd[1]), 'h3C);

      // R1: pseudo-random mixed sweep on both geometries
      lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         do_access(i % 2, lf[5:4] == 2'b00, int'(lf[3:0]), lf[15:8], "R1", h, cl);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL R4 watchdog expired: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule